// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Prescaler

This block is a watchdog that restarts the processor when software stops servicing it. It counts a clock-enable strobe from a dedicated low-power oscillator, so it keeps counting when the system clock source fails. The block samples that strobe in the system clock domain. Each accepted strobe passes through four stages in turn. The first is a fixed divide-by-4 stage that produces the base tick. The second is a coarse prescaler whose division is a power of eight. The third is a fine prescaler with a division from 1 to 16. The last is an 8-bit up-counter. A wrap of that counter is the watchdog event.

Two inputs decide whether the watchdog runs. A non-volatile configuration enable forces it on. When that enable is low, a software enable decides on its own. The enable register lives outside the block and is cleared there by any device reset.

Software keeps the timer from expiring with a clear strobe. Entering a power-saving state restarts the timer in the same way. When the counter wraps, the block raises a single-cycle wake-up pulse if the device is sleeping or idle. Otherwise it raises a single-cycle reset pulse.

Top module: `wdt_top`

## Requirements
- R1: After an active-low reset, both output pulses are low and all four counting stages start from zero.
- R2: While `cfg_en_i` is 1, the watchdog runs whatever the value of `sw_en_i`.
- R3: While `cfg_en_i` is 0, the watchdog runs only when `sw_en_i` is 1. While it is disabled, no pulse is produced and every stage is held at zero, so re-enabling gives a full period counted from the first enabled cycle.
- R4: The low-power strobe is first divided by a fixed factor of 4 to form the base tick.
- R5: The coarse prescaler divides the base tick by 8 to the power of `coarse_sel_i`. Select values 0, 1, 2 and 3 give 1, 8, 64 and 512.
- R6: The fine prescaler divides by `fine_sel_i` + 1, so select values 0 to 15 give divisions of 1 to 16.
- R7: The counter is 8 bits wide. The event occurs on its wrap from 255, after a total of 4 × coarse × fine × 256 accepted strobes. The pulse is visible in the cycle after the clock edge that accepts the last strobe.
- R8: If `sleep_i` is 1 at the event, `wake_pulse_o` fires and `rst_pulse_o` stays low. If `sleep_i` is 0, `rst_pulse_o` fires and `wake_pulse_o` stays low.
- R9: `clrwdt_i` clears all four stages, and so does the device reset. The next event then comes one full period later.
- R10: `pwrsav_i` clears all four stages in the same way as the clear strobe.
- R11: Each pulse lasts exactly one cycle. After an event the stages restart from zero, so the next event follows exactly one period later.
- R12: Only cycles with `lp_tick_i` at 1 advance the timer. With the strobe held low, no event ever occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low device reset |
| lp_tick_i | input | 1 | Low-power oscillator strobe, one cycle per oscillator period |
| cfg_en_i | input | 1 | Configuration enable; 1 forces the watchdog on |
| sw_en_i | input | 1 | Software enable, used when `cfg_en_i` is 0 |
| coarse_sel_i | input | CA_SEL_W | Coarse prescaler select |
| fine_sel_i | input | FB_SEL_W | Fine prescaler select |
| clrwdt_i | input | 1 | Service strobe that restarts the timer |
| pwrsav_i | input | 1 | Power-save entry strobe that restarts the timer |
| sleep_i | input | 1 | Device is in sleep or idle |
| rst_pulse_o | output | 1 | One-cycle processor reset request |
| wake_pulse_o | output | 1 | One-cycle wake-up request |

## Verification
The bench builds the block with a 3-bit event counter and a coarse step of 4 instead of 8. With these values the largest period is 32768 strobes rather than millions. This lets the bench sweep every coarse select and every fine select, and still run the largest combined setting to its end. Each period is predicted as 4 × 4^coarse × (fine+1) × 8 and compared with the edge count at which a pulse appears. The same arithmetic with a half-rate strobe checks that idle cycles add no count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Output event pair registered by the top level.
    typedef struct packed {
        logic rst;
        logic wake;
    } wdt_pulse_t;

    // Bits needed to hold the largest coarse count.
    function automatic int unsigned coarse_width(int unsigned sel_w, int unsigned step_log2);
        return step_log2 * ((1 << sel_w) - 1);
    endfunction

endpackage

// File: rtl/wdt_div_stage.sv
// Generic divider stage: counts input ticks from 0 up to limit_i and emits
// one output tick on the input tick that completes the count.
module wdt_div_stage #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         hold_i,
    input  logic         tick_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;
    logic   wrap;

    // >= keeps the stage from running past a limit lowered mid-count
    assign wrap   = tick_i && (st_q.cnt >= limit_i);
    assign tick_o = wrap && !hold_i;

    always_comb begin
        st_d = st_q;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/wdt_fixed_div.sv
// Constant divider that forms the base tick from the oscillator strobe.
module wdt_fixed_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic tick_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_w;
            assign unused_w = clk_i ^ rst_ni;
            assign tick_o   = tick_i && !hold_i;
        end else begin : g_div
            localparam int unsigned W = $clog2(DIV);
            localparam logic [W-1:0] LIMIT = W'(DIV - 1);
            wdt_div_stage #(.W(W)) i_stage (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .hold_i (hold_i),
                .tick_i (tick_i),
                .limit_i(LIMIT),
                .tick_o (tick_o)
            );
        end
    endgenerate
endmodule

// File: rtl/wdt_coarse_pre.sv
// Coarse prescaler: division of 2^(STEP_LOG2*sel).
module wdt_coarse_pre #(
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned STEP_LOG2 = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned CW = wdt_pkg::coarse_width(SEL_W, STEP_LOG2);

    generate
        if (CW == 0) begin : g_pass
            logic unused_w;
            assign unused_w = clk_i ^ rst_ni ^ (^sel_i);
            assign tick_o   = tick_i && !hold_i;
        end else begin : g_div
            localparam logic [CW-1:0] ONES = {CW{1'b1}};
            int unsigned   shamt;
            logic [CW-1:0] limit;

            assign shamt = STEP_LOG2 * 32'(sel_i);
            // limit = 2^shamt - 1; a shift by CW or more yields all ones
            assign limit = ~(ONES << shamt);

            wdt_div_stage #(.W(CW)) i_stage (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .hold_i (hold_i),
                .tick_i (tick_i),
                .limit_i(limit),
                .tick_o (tick_o)
            );
        end
    endgenerate
endmodule

// File: rtl/wdt_fine_pre.sv
// Fine prescaler: division of sel + 1.
module wdt_fine_pre #(
    parameter int unsigned SEL_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    wdt_div_stage #(.W(SEL_W)) i_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (hold_i),
        .tick_i (tick_i),
        .limit_i(sel_i),
        .tick_o (tick_o)
    );
endmodule

// File: rtl/wdt_event_counter.sv
// Final up-counter; ovf_o marks the tick that wraps it to zero.
module wdt_event_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic tick_i,
    output logic ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    assign ovf_o = tick_i && !hold_i && (&st_q.cnt);

    always_comb begin
        st_d = st_q;
        if (hold_i)      st_d.cnt = '0;
        else if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int unsigned LP_DIV       = 4,
    parameter int unsigned CA_SEL_W     = 2,
    parameter int unsigned CA_STEP_LOG2 = 3,
    parameter int unsigned FB_SEL_W     = 4,
    parameter int unsigned CNT_W        = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                lp_tick_i,
    input  logic                cfg_en_i,
    input  logic                sw_en_i,
    input  logic [CA_SEL_W-1:0] coarse_sel_i,
    input  logic [FB_SEL_W-1:0] fine_sel_i,
    input  logic                clrwdt_i,
    input  logic                pwrsav_i,
    input  logic                sleep_i,
    output logic                rst_pulse_o,
    output logic                wake_pulse_o
);
    import wdt_pkg::*;

    logic       run_en;
    logic       hold;
    logic       base_tick;
    logic       coarse_tick;
    logic       fine_tick;
    logic       ovf;
    wdt_pulse_t out_d, out_q;

    // Configuration enable overrides; software enable acts only when it is low.
    assign run_en = cfg_en_i | sw_en_i;
    // Disable, service and power-save entry all restart the whole chain.
    assign hold   = !run_en | clrwdt_i | pwrsav_i;

    wdt_fixed_div #(.DIV(LP_DIV)) i_base (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold),
        .tick_i(lp_tick_i),
        .tick_o(base_tick)
    );

    wdt_coarse_pre #(.SEL_W(CA_SEL_W), .STEP_LOG2(CA_STEP_LOG2)) i_coarse (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold),
        .tick_i(base_tick),
        .sel_i (coarse_sel_i),
        .tick_o(coarse_tick)
    );

    wdt_fine_pre #(.SEL_W(FB_SEL_W)) i_fine (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold),
        .tick_i(coarse_tick),
        .sel_i (fine_sel_i),
        .tick_o(fine_tick)
    );

    wdt_event_counter #(.CNT_W(CNT_W)) i_count (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .hold_i(hold),
        .tick_i(fine_tick),
        .ovf_o (ovf)
    );

    always_comb begin
        out_d      = '0;
        out_d.wake = ovf && sleep_i;
        out_d.rst  = ovf && !sleep_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign rst_pulse_o  = out_q.rst;
    assign wake_pulse_o = out_q.wake;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic lp_tick_i,
    input logic cfg_en_i,
    input logic sw_en_i,
    input logic clrwdt_i,
    input logic pwrsav_i,
    input logic sleep_i,
    input logic rst_pulse_o,
    input logic wake_pulse_o
);
    // R11: any pulse is followed by a quiet cycle
    a_r11_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_pulse_o || wake_pulse_o) |=> !(rst_pulse_o || wake_pulse_o));

    // R8: a wake-up only follows an edge that saw sleep
    a_r8_wake_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_pulse_o |-> $past(sleep_i));

    // R8: a reset only follows an edge that saw the device awake
    a_r8_reset_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_pulse_o |-> !$past(sleep_i));

    // R3: no event from an edge where the watchdog was disabled
    a_r3_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!(cfg_en_i || sw_en_i)) |-> !(rst_pulse_o || wake_pulse_o));

    // R9 / R10: a service or power-save strobe never coincides with an event
    a_r9_clear_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clrwdt_i || pwrsav_i) |-> !(rst_pulse_o || wake_pulse_o));

    // R12: an edge without a strobe cannot complete a period
    a_r12_tick_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!lp_tick_i) |-> !(rst_pulse_o || wake_pulse_o));
endmodule

bind wdt_top wdt_checker i_wdt_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lp_tick_i   (lp_tick_i),
    .cfg_en_i    (cfg_en_i),
    .sw_en_i     (sw_en_i),
    .clrwdt_i    (clrwdt_i),
    .pwrsav_i    (pwrsav_i),
    .sleep_i     (sleep_i),
    .rst_pulse_o (rst_pulse_o),
    .wake_pulse_o(wake_pulse_o)
);

// File: tb/test_wdt_top.sv
`timescale 1ns/1ps
module test_wdt_top;
    localparam int unsigned CNT_W = 3;
    localparam int unsigned STEP  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_tick = 1'b0;
    logic       cfg_en = 1'b1;
    logic       sw_en = 1'b0;
    logic [1:0] coarse_sel = '0;
    logic [3:0] fine_sel = '0;
    logic       clrwdt = 1'b0;
    logic       pwrsav = 1'b0;
    logic       sleep = 1'b0;
    logic       rst_pulse;
    logic       wake_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    wdt_top #(.LP_DIV(4), .CA_SEL_W(2), .CA_STEP_LOG2(STEP), .FB_SEL_W(4), .CNT_W(CNT_W)) i_wdt_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .lp_tick_i   (lp_tick),
        .cfg_en_i    (cfg_en),
        .sw_en_i     (sw_en),
        .coarse_sel_i(coarse_sel),
        .fine_sel_i  (fine_sel),
        .clrwdt_i    (clrwdt),
        .pwrsav_i    (pwrsav),
        .sleep_i     (sleep),
        .rst_pulse_o (rst_pulse),
        .wake_pulse_o(wake_pulse)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int period(int a, int b);
        return 4 * (1 << (STEP * a)) * (b + 1) * (1 << CNT_W);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // mode 0: strobe every cycle, 1: every other cycle, 2: never
    task automatic run_period(input bit do_clr, input bit use_ps, input int mode,
                              input int lim, output int got, output bit w, output bit r);
        got = -1; w = 1'b0; r = 1'b0;
        if (do_clr) begin
            @(negedge clk);
            lp_tick = 1'b1;
            if (use_ps) pwrsav = 1'b1; else clrwdt = 1'b1;
            @(posedge clk);
        end
        for (int j = 1; j <= lim; j++) begin
            @(negedge clk);
            clrwdt  = 1'b0;
            pwrsav  = 1'b0;
            lp_tick = (mode == 0) ? 1'b1 : (mode == 1) ? j[0] : 1'b0;
            @(posedge clk);
            #1;
            if (rst_pulse || wake_pulse) begin
                got = j; w = wake_pulse; r = rst_pulse;
                break;
            end
        end
    endtask

    task automatic expect_rst(string req, int a, int b, bit do_clr);
        int got; bit w; bit r; int n;
        n = period(a, b);
        coarse_sel = 2'(a); fine_sel = 4'(b);
        run_period(do_clr, 1'b0, 0, 2 * n + 8, got, w, r);
        check(got == n, req, $sformatf("period a=%0d b=%0d", a, b), got, n);
        check(r && !w, req, "reset pulse kind", {30'd0, w, r}, 1);
    endtask

    initial begin
        int got; bit w; bit r; int n;
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(!rst_pulse && !wake_pulse, "R1", "outputs in reset", {31'd0, rst_pulse | wake_pulse}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: configuration enable alone; R4 base divide with unity prescalers
        cfg_en = 1'b1; sw_en = 1'b0;
        expect_rst("R2", 0, 0, 1'b1);
        expect_rst("R4", 0, 0, 1'b1);
        // R11: next event one period later with no service
        expect_rst("R11", 0, 0, 1'b0);
        @(posedge clk); #1;
        check(!rst_pulse, "R11", "pulse width", {31'd0, rst_pulse}, 0);

        // R5: coarse sweep
        for (int a = 0; a < 4; a++) expect_rst("R5", a, 0, 1'b1);
        // R6: fine sweep
        for (int b = 0; b < 16; b++) expect_rst("R6", 0, b, 1'b1);
        // R7: combined settings
        expect_rst("R7", 2, 5, 1'b1);
        expect_rst("R7", 3, 15, 1'b1);
        expect_rst("R7", 1, 9, 1'b1);

        // R8: sleep gives wake-up
        coarse_sel = 2'd0; fine_sel = 4'd1; n = period(0, 1);
        sleep = 1'b1;
        run_period(1'b1, 1'b0, 0, 2 * n, got, w, r);
        check(got == n, "R8", "wake period", got, n);
        check(w && !r, "R8", "wake pulse kind", {30'd0, w, r}, 2);
        sleep = 1'b0;
        expect_rst("R8", 0, 1, 1'b1);

        // R3: both enables low -> nothing
        cfg_en = 1'b0; sw_en = 1'b0;
        run_period(1'b1, 1'b0, 0, 3 * n, got, w, r);
        check(got == -1, "R3", "disabled no event", got, -1);
        // R3: software enable alone runs it
        sw_en = 1'b1;
        expect_rst("R3", 0, 1, 1'b1);
        // R3: dropping the software enable mid-period restarts the count
        run_period(1'b0, 1'b0, 0, 20, got, w, r);
        @(negedge clk); sw_en = 1'b0;
        repeat (4) @(posedge clk);
        #1 sw_en = 1'b1;
        run_period(1'b0, 1'b0, 0, 2 * n, got, w, r);
        check(got == n, "R3", "full period after re-enable", got, n);
        cfg_en = 1'b1; sw_en = 1'b0;

        // R9: clear mid-period
        run_period(1'b1, 1'b0, 0, 20, got, w, r);
        check(got == -1, "R9", "no early event", got, -1);
        run_period(1'b1, 1'b0, 0, 2 * n, got, w, r);
        check(got == n, "R9", "period after clear", got, n);
        // R9 / R1: device reset mid-period
        run_period(1'b1, 1'b0, 0, 20, got, w, r);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        run_period(1'b0, 1'b0, 0, 2 * n, got, w, r);
        check(got == n, "R9", "period after device reset", got, n);

        // R10: power-save strobe mid-period
        run_period(1'b1, 1'b0, 0, 20, got, w, r);
        run_period(1'b1, 1'b1, 0, 2 * n, got, w, r);
        check(got == n, "R10", "period after power-save", got, n);

        // R12: half-rate strobe and absent strobe
        coarse_sel = 2'd0; fine_sel = 4'd0; n = period(0, 0);
        run_period(1'b1, 1'b0, 1, 3 * n, got, w, r);
        check(got == 2 * n - 1, "R12", "half-rate period", got, 2 * n - 1);
        run_period(1'b1, 1'b0, 2, 3 * n, got, w, r);
        check(got == -1, "R12", "no strobe no event", got, -1);

        summary();
    end

    initial begin
        wait (cyc > 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        summary();
    end
endmodule